// File: doc/BRIEF.md
# Dual-Bank Read Source Selector

This block sits on the read side of a flash macro with two banks, where one bank can be read while the other is busy with a program or erase. For each read it decodes which bank the word address targets and picks the word returned to the host. A busy bank returns the status word from the status logic. A bank in identification mode returns the manufacturer or device code. A bank in query mode returns a small query string. In every other case the bank returns the array word for the address.

The command decoder sets each bank's mode through a one-cycle mode-write strobe. Each bank keeps its own mode, so an identification or query session on one bank leaves reads of the other bank unchanged. The selected word and a code naming its source are registered one cycle after the read is sampled. The source code serves as a debug view of the decision.

Top module: `dbank_read_sel`

## Requirements
- R1: The bank field is the two most significant bits of `rdAddr`. A field value below `BANK_SPLIT` selects bank 0, and any other value selects bank 1.
- R2: A read of a bank whose `bankBusy` bit is set returns `statusWord` with source code 1. This holds whatever that bank's mode is, and whatever the other bank is doing.
- R3: A read of an idle bank in array mode returns `arrayData` with source code 0. This also holds while the other bank is busy.
- R4: `modeWe` loads the mode of bank `modeBank` from `modeSel`: 0 is array, 1 is identification, 2 is query, and 3 is taken as array. The other bank's mode does not change. The new mode applies to reads sampled at later edges. A read sampled at the same edge as the mode write still uses the old mode.
- R5: The in-bank offset is `rdAddr` without its bank field. A read of an idle bank in identification mode uses source code 2. It returns 0x00BF at offset 0, `DEVICE_CODE` at offset 1, and 0x0000 at every other offset.
- R6: Identification mode stays in place across any number of reads and addresses in that bank until a later mode write for that bank.
- R7: A read of an idle bank in query mode uses source code 3. It returns 0x0051, 0x0052 and 0x0059 at offsets 0x10, 0x11 and 0x12, and 0x0000 at every other offset.
- R8: When `rdValid` is sampled high at a clock edge, `outData` and `outSrc` take that read's result at the same edge and `outValid` is high for the following cycle. When `rdValid` is low, `outValid` drops and `outData` and `outSrc` hold their values.
- R9: During and after reset, before any read, `outValid`, `outData` and `outSrc` are zero and both banks are in array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdValid | input | 1 | Read request for this cycle |
| rdAddr | input | ADDR_W | Word address of the read |
| bankBusy | input | 2 | Per-bank program/erase in progress |
| modeWe | input | 1 | Mode write strobe from the command decoder |
| modeBank | input | 1 | Bank whose mode is written |
| modeSel | input | 2 | New mode: 0 array, 1 identification, 2 query |
| arrayData | input | DATA_W | Array word at `rdAddr` |
| statusWord | input | DATA_W | Status word for the busy bank |
| outData | output | DATA_W | Registered read result |
| outSrc | output | 2 | Source of the result: 0 array, 1 status, 2 identification, 3 query |
| outValid | output | 1 | Result registered this cycle |

## Verification
The bench builds the block with `ADDR_W` = 8, `BANK_SPLIT` = 3 and a non-default `DEVICE_CODE`. With an 8-bit address, the offset is only six bits wide, so random addresses often land on the identification offsets 0 and 1 and on the query offsets 0x10 to 0x12. A split of three puts both banks on a field boundary away from the default: fields 0 to 2 map to bank 0 and field 3 to bank 1. This exercises a decode that does not depend on the top bit alone. Random busy patterns and mode writes on the same cycle as reads reach the ordering case in R4 and reads of an idle bank while the other bank is busy.

// File: rtl/dbank_read_pkg.sv
package dbank_read_pkg;

  localparam int NUM_BANKS   = 2;
  localparam int BANK_FLD_W  = 2;
  localparam logic [15:0] MFR_CODE = 16'h00BF;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_ID    = 2'd1,
    MODE_CFI   = 2'd2,
    MODE_RSVD  = 2'd3
  } bankMode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2,
    SRC_CFI    = 2'd3
  } readSrc_e;

  typedef struct packed {
    logic     load;
    readSrc_e src;
  } rdStrobe_t;

endpackage

// File: rtl/dbank_read_ctrl.sv
module dbank_read_ctrl
  import dbank_read_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BANK_SPLIT = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rdValid,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [NUM_BANKS-1:0]      bankBusy,
  input  logic                      modeWe,
  input  logic                      modeBank,
  input  logic [1:0]                modeSel,
  output rdStrobe_t                 strobe,
  output logic [2*NUM_BANKS-1:0]    bankModeFlat
);

  localparam logic [BANK_FLD_W-1:0] SPLIT_VAL = BANK_FLD_W'(BANK_SPLIT);

  bankMode_e                modeQ [NUM_BANKS];
  logic [BANK_FLD_W-1:0]    bankField;
  logic                     tgtBank;
  bankMode_e                nextMode;
  bankMode_e                tgtMode;

  assign bankField = rdAddr[ADDR_W-1 -: BANK_FLD_W];
  assign tgtBank   = (bankField >= SPLIT_VAL);
  assign nextMode  = (modeSel == MODE_RSVD) ? MODE_ARRAY : bankMode_e'(modeSel);
  assign tgtMode   = modeQ[tgtBank];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) modeQ[b] <= MODE_ARRAY;
    end else if (modeWe) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (modeBank == 1'(b)) modeQ[b] <= nextMode;
    end
  end

  always_comb begin
    strobe.load = rdValid;
    if (bankBusy[tgtBank]) begin
      strobe.src = SRC_STATUS;
    end else begin
      unique case (tgtMode)
        MODE_ID:  strobe.src = SRC_ID;
        MODE_CFI: strobe.src = SRC_CFI;
        default:  strobe.src = SRC_ARRAY;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_flat
    assign bankModeFlat[2*g +: 2] = modeQ[g];
  end

endmodule

// File: rtl/dbank_read_dp.sv
module dbank_read_dp
  import dbank_read_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 16,
  parameter logic [15:0] DEVICE_CODE = 16'h22C4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outSrc,
  output logic              outValid
);

  localparam int OFF_W = ADDR_W - BANK_FLD_W;

  logic [OFF_W-1:0]  offset;
  logic [DATA_W-1:0] idWord;
  logic [DATA_W-1:0] cfiWord;
  logic [DATA_W-1:0] selWord;

  assign offset = rdAddr[OFF_W-1:0];

  always_comb begin
    idWord = '0;
    if (offset[OFF_W-1:1] == '0)
      idWord = offset[0] ? DATA_W'(DEVICE_CODE) : DATA_W'(MFR_CODE);
  end

  always_comb begin
    unique case (offset)
      OFF_W'(16): cfiWord = DATA_W'(16'h0051);
      OFF_W'(17): cfiWord = DATA_W'(16'h0052);
      OFF_W'(18): cfiWord = DATA_W'(16'h0059);
      default:    cfiWord = '0;
    endcase
  end

  always_comb begin
    unique case (strobe.src)
      SRC_STATUS: selWord = statusWord;
      SRC_ID:     selWord = idWord;
      SRC_CFI:    selWord = cfiWord;
      default:    selWord = arrayData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outSrc   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outData <= selWord;
        outSrc  <= strobe.src;
      end
    end
  end

endmodule

// File: rtl/dbank_read_sel.sv
module dbank_read_sel
  import dbank_read_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 16,
  parameter int          BANK_SPLIT  = 1,
  parameter logic [15:0] DEVICE_CODE = 16'h22C4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        bankBusy,
  input  logic              modeWe,
  input  logic              modeBank,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outSrc,
  output logic              outValid
);

  if (ADDR_W < BANK_FLD_W + 5) begin : g_bad_addr
    $error("ADDR_W too small for the query offsets");
  end
  if (BANK_SPLIT < 1 || BANK_SPLIT > 3) begin : g_bad_split
    $error("BANK_SPLIT must be 1 to 3");
  end

  rdStrobe_t                  strobe;
  logic [2*NUM_BANKS-1:0]     bankModeFlat;

  dbank_read_ctrl #(
    .ADDR_W     (ADDR_W),
    .BANK_SPLIT (BANK_SPLIT)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rdValid      (rdValid),
    .rdAddr       (rdAddr),
    .bankBusy     (bankBusy),
    .modeWe       (modeWe),
    .modeBank     (modeBank),
    .modeSel      (modeSel),
    .strobe       (strobe),
    .bankModeFlat (bankModeFlat)
  );

  dbank_read_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .DEVICE_CODE (DEVICE_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdAddr     (rdAddr),
    .arrayData  (arrayData),
    .statusWord (statusWord),
    .outData    (outData),
    .outSrc     (outSrc),
    .outValid   (outValid)
  );

endmodule

// File: rtl/dbank_read_sel_chk.sv
module dbank_read_sel_chk #(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 16,
  parameter int          BANK_SPLIT  = 1,
  parameter logic [15:0] DEVICE_CODE = 16'h22C4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [1:0]        bankBusy,
  input logic              modeWe,
  input logic              modeBank,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] statusWord,
  input logic [DATA_W-1:0] outData,
  input logic [1:0]        outSrc,
  input logic              outValid,
  input logic [3:0]        bankModeFlat
);

  logic       hitBank;
  logic [1:0] hitMode;

  assign hitBank = (int'(rdAddr[ADDR_W-1:ADDR_W-2]) >= BANK_SPLIT);
  assign hitMode = hitBank ? bankModeFlat[3:2] : bankModeFlat[1:0];

  assert_busy_status_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && bankBusy[hitBank] |=> outSrc == 2'd1 && outData == $past(statusWord));

  assert_idle_array_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !bankBusy[hitBank] && (hitMode == 2'd0) |=>
      outSrc == 2'd0 && outData == $past(arrayData));

  assert_read_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> outValid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !outValid && $stable(outData) && $stable(outSrc));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !modeWe |=> $stable(bankModeFlat));

  assert_other_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    modeWe && !modeBank |=> $stable(bankModeFlat[3:2]));

  assert_id_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSrc == 2'd2 |->
      (outData == DATA_W'(16'h00BF) || outData == DATA_W'(DEVICE_CODE) || outData == '0));

endmodule

bind dbank_read_sel dbank_read_sel_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .BANK_SPLIT  (BANK_SPLIT),
  .DEVICE_CODE (DEVICE_CODE)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rdValid      (rdValid),
  .rdAddr       (rdAddr),
  .bankBusy     (bankBusy),
  .modeWe       (modeWe),
  .modeBank     (modeBank),
  .arrayData    (arrayData),
  .statusWord   (statusWord),
  .outData      (outData),
  .outSrc       (outSrc),
  .outValid     (outValid),
  .bankModeFlat (bankModeFlat)
);

// File: tb/dbank_read_sel_bench.sv
module dbank_read_sel_bench;

  localparam int          AW    = 8;
  localparam int          DW    = 16;
  localparam int          SPLIT = 3;
  localparam logic [15:0] DEV   = 16'h1D5A;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdValid = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [1:0]    bankBusy = '0;
  logic          modeWe = 1'b0;
  logic          modeBank = 1'b0;
  logic [1:0]    modeSel = '0;
  logic [DW-1:0] arrayData;
  logic [DW-1:0] statusWord = '0;
  logic [DW-1:0] outData;
  logic [1:0]    outSrc;
  logic          outValid;

  always #10 clk = ~clk;

  // behavioural array contents
  assign arrayData = {rdAddr, ~rdAddr} ^ 16'h3C5A;

  dbank_read_sel #(
    .ADDR_W(AW), .DATA_W(DW), .BANK_SPLIT(SPLIT), .DEVICE_CODE(DEV)
  ) u_dbank_read_sel (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdAddr(rdAddr),
    .bankBusy(bankBusy), .modeWe(modeWe), .modeBank(modeBank),
    .modeSel(modeSel), .arrayData(arrayData), .statusWord(statusWord),
    .outData(outData), .outSrc(outSrc), .outValid(outValid)
  );

  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  bit    started = 0;
  bit    done    = 0;
  string tag     = "R9";

  // reference model state
  int            refMode [2];
  logic [DW-1:0] expData  = '0;
  int            expSrc   = 0;
  bit            expValid = 0;
  string         expTag   = "R9";

  always @(posedge clk) begin
    int bank;
    int off;
    cycles++;
    if (!rstN) begin
      refMode[0] = 0; refMode[1] = 0;
      expData = '0; expSrc = 0; expValid = 0; expTag = "R9";
      started = 1;
    end else begin
      bank = (int'(rdAddr[AW-1:AW-2]) >= SPLIT) ? 1 : 0;   // R1
      off  = int'(rdAddr[AW-3:0]);
      expValid = rdValid;
      if (rdValid) begin
        expTag = tag;
        if (bankBusy[bank]) begin
          expSrc = 1; expData = statusWord;
        end else if (refMode[bank] == 1) begin
          expSrc = 2;
          expData = (off == 0) ? 16'h00BF : (off == 1) ? DEV : 16'h0000;
        end else if (refMode[bank] == 2) begin
          expSrc = 3;
          expData = (off == 16) ? 16'h0051 : (off == 17) ? 16'h0052 :
                    (off == 18) ? 16'h0059 : 16'h0000;
        end else begin
          expSrc = 0; expData = arrayData;
        end
      end else begin
        expTag = "R8";
      end
      if (modeWe) refMode[modeBank] = (modeSel == 2'd3) ? 0 : int'(modeSel);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (outValid !== expValid || outData !== expData || outSrc !== 2'(expSrc)) begin
        fails++;
        $display("FAIL %s: valid=%0b data=%04h src=%0d expected valid=%0b data=%04h src=%0d",
                 expTag, outValid, outData, outSrc, expValid, expData, expSrc);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected end before %0d cycles", 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step(input bit rv, input logic [AW-1:0] a, input logic [1:0] busy,
                      input bit mwe, input bit mb, input logic [1:0] ms, input string t);
    rdValid = rv; rdAddr = a; bankBusy = busy;
    modeWe = mwe; modeBank = mb; modeSel = ms; tag = t;
    statusWord = 16'(($urandom));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);          // R9: reset values compared here
    rstN = 1'b1;
    @(negedge clk);
    step(1, 8'h05, 2'b00, 0, 0, 0, "R3_bank0");
    step(1, 8'hC5, 2'b00, 0, 0, 0, "R3_bank1");
    step(1, 8'hC3, 2'b10, 0, 0, 0, "R2_busy1");
    step(1, 8'h83, 2'b10, 0, 0, 0, "R1_field2_bank0");
    step(1, 8'h43, 2'b01, 0, 0, 0, "R2_busy0");
    step(1, 8'hC7, 2'b01, 0, 0, 0, "R3_idle_while_other_busy");
    step(0, 8'h00, 2'b00, 1, 0, 1, "R4_enter_id");
    step(1, 8'h00, 2'b00, 0, 0, 0, "R5_mfr");
    step(1, 8'h01, 2'b00, 0, 0, 0, "R5_dev");
    step(1, 8'h02, 2'b00, 0, 0, 0, "R5_other");
    step(1, 8'h41, 2'b00, 0, 0, 0, "R6_repeat");
    step(1, 8'h80, 2'b00, 0, 0, 0, "R6_repeat");
    step(1, 8'hC1, 2'b00, 0, 0, 0, "R4_other_array");
    step(1, 8'h00, 2'b01, 0, 0, 0, "R2_busy_over_id");
    step(0, 8'h00, 2'b00, 1, 1, 2, "R4_enter_cfi");
    step(1, 8'hD0, 2'b00, 0, 0, 0, "R7_q");
    step(1, 8'hD1, 2'b00, 0, 0, 0, "R7_r");
    step(1, 8'hD2, 2'b00, 0, 0, 0, "R7_y");
    step(1, 8'hD3, 2'b00, 0, 0, 0, "R7_other");
    step(1, 8'h01, 2'b00, 0, 0, 0, "R4_bank0_still_id");
    step(0, 8'h12, 2'b00, 0, 0, 0, "R8_hold");
    step(0, 8'h34, 2'b00, 0, 0, 0, "R8_hold");
    step(1, 8'hC0, 2'b00, 1, 1, 3, "R4_same_edge_old_mode");
    step(1, 8'hD0, 2'b00, 0, 0, 0, "R4_rsvd_is_array");
    step(1, 8'h00, 2'b00, 1, 0, 0, "R4_same_edge_id");
    step(1, 8'h00, 2'b00, 0, 0, 0, "R4_exit_id");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[1:0] != 2'b00), r[9:2], r[11:10], (r[14:12] == 3'd0), r[15], r[17:16],
           "R1_R2_R3_random");
    end
    step(0, 8'h00, 2'b00, 0, 0, 0, "R8_end");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule